// File: doc/BRIEF.md
# Relocatable Register Window Decoder

This block decides, for every bus access, whether the access targets the block's own placement register or the 8-Kbyte window of on-chip registers and RAM. The bus carries a 32-bit address and a 3-bit function code. Function code 3'b111 marks the CPU address space. The placement register is reached only at one fixed CPU-space address. It is not memory-mapped.

Software writes the starting address of the window, aligned to 8 Kbytes, into the placement register and sets a valid flag in the same word. From then on, any access outside CPU space whose upper 19 address bits match the stored base raises a window select and presents the low 13 address bits as an offset into the window. Both decisions are combinational on the current bus signals. The register itself changes only on a clock edge.

Top module: `win_decoder`

## Requirements
- R1: After synchronous reset the valid flag and the stored base are zero, a register read returns 0x00000000 and no window hit is signalled for any address.
- R2: `cfg_sel` is high exactly when `bus_stb` is high, `bus_fc` equals 3'b111 and `bus_addr` equals 0x0003FF00.
- R3: An access to 0x0003FF00 with a function code other than 3'b111 neither selects nor modifies the placement register.
- R4: A register write stores `bus_wdata[31:13]` as the base and `bus_wdata[0]` as the valid flag. A later read returns {base, 12'b0, valid}, so bits 12..1 read as zero whatever was written.
- R5: `win_hit` is high exactly when `bus_stb` is high, the valid flag is set, `bus_fc` is not 3'b111 and `bus_addr[31:13]` equals the stored base. On a hit, `win_offset` equals `bus_addr[12:0]`.
- R6: A CPU-space access (function code 3'b111) to any address other than 0x0003FF00 raises neither `cfg_sel` nor `win_hit`.
- R7: When `win_hit` is low, `win_offset` is zero.
- R8: `cfg_rdata` carries the register contents only during a selected read (`cfg_sel` high, `bus_wr` low) and is zero otherwise.
- R9: The placement register changes only on a clock edge at which a selected write is present. A write with `bus_stb` low leaves it unchanged, and a selected write becomes visible on the cycle after the edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | 32 | Bus address |
| bus_fc | input | 3 | Bus function code (3'b111 = CPU space) |
| bus_stb | input | 1 | Access qualifier, high while the address is valid |
| bus_wr | input | 1 | High for a write, low for a read |
| bus_wdata | input | 32 | Write data for the placement register |
| cfg_sel | output | 1 | Placement register access decoded |
| cfg_rdata | output | 32 | Placement register read data |
| win_hit | output | 1 | Access falls inside the enabled window |
| win_offset | output | 13 | Byte offset of the access inside the window |

## Verification
The bench builds the block with its defaults: a 32-bit address, a 13-bit offset (8-Kbyte window) and a 3-bit function code. With these values a base written at 0x00402000 allows the bench to reach both window edges, 0x00402000 and 0x00403FFF, and the first address on each side outside the window. The one fixed register address can also be driven with all eight function codes. Random traffic mixes register writes, in-window and out-of-window accesses and all function codes, so the window moves many times during a run, and hits are checked against each newly written base.

// File: rtl/win_dec_pkg.sv
package win_dec_pkg;

    // Default geometry of the decoder
    localparam int          ADDR_W_D   = 32;
    localparam int          FC_W_D     = 3;
    localparam int          OFS_W_D    = 13;
    localparam logic [31:0] CFG_ADDR_D = 32'h0003_FF00;
    localparam logic [2:0]  CPU_FC_D   = 3'b111;

    // Kind of access seen on the bus in the current cycle
    typedef enum logic [1:0] {
        ACC_NONE   = 2'd0,
        ACC_CFG_RD = 2'd1,
        ACC_CFG_WR = 2'd2,
        ACC_OTHER  = 2'd3
    } acc_kind_e;

    function automatic logic is_cfg(acc_kind_e k);
        return (k == ACC_CFG_RD) || (k == ACC_CFG_WR);
    endfunction

endpackage

// File: rtl/win_cfg_decode.sv
module win_cfg_decode
    import win_dec_pkg::*;
#(
    parameter int              ADDR_W   = ADDR_W_D,
    parameter int              FC_W     = FC_W_D,
    parameter logic [ADDR_W-1:0] CFG_ADDR = CFG_ADDR_D,
    parameter logic [FC_W-1:0]   CPU_FC   = CPU_FC_D
) (
    input  logic [ADDR_W-1:0] addr,
    input  logic [FC_W-1:0]   fc,
    input  logic              stb,
    input  logic              wr,
    output acc_kind_e         kind,
    output logic              cpu_space
);
    logic at_cfg;

    always_comb begin
        cpu_space = (fc == CPU_FC);
        at_cfg    = (addr == CFG_ADDR);
        if (!stb)
            kind = ACC_NONE;
        else if (cpu_space && at_cfg)
            kind = wr ? ACC_CFG_WR : ACC_CFG_RD;
        else
            kind = ACC_OTHER;
    end
endmodule

// File: rtl/win_base_reg.sv
module win_base_reg #(
    parameter int ADDR_W = 32,
    parameter int OFS_W  = 13,
    localparam int BASE_W = ADDR_W - OFS_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [BASE_W-1:0] base_d,
    input  logic              valid_d,
    output logic [BASE_W-1:0] base_q,
    output logic              valid_q,
    output logic [ADDR_W-1:0] rd_word
);
    always_ff @(posedge clk) begin
        if (rst) begin
            base_q  <= '0;
            valid_q <= 1'b0;
        end else if (wr_en) begin
            base_q  <= base_d;
            valid_q <= valid_d;
        end
    end

    assign rd_word = {base_q, {(OFS_W-1){1'b0}}, valid_q};
endmodule

// File: rtl/win_match.sv
module win_match #(
    parameter int ADDR_W = 32,
    parameter int OFS_W  = 13,
    localparam int BASE_W = ADDR_W - OFS_W
) (
    input  logic [ADDR_W-1:0] addr,
    input  logic [BASE_W-1:0] base,
    input  logic              enable,
    input  logic              qualify,
    output logic              hit,
    output logic [OFS_W-1:0]  offset
);
    always_comb begin
        hit    = enable && qualify && (addr[ADDR_W-1:OFS_W] == base);
        offset = hit ? addr[OFS_W-1:0] : '0;
    end
endmodule

// File: rtl/win_decoder.sv
module win_decoder
    import win_dec_pkg::*;
#(
    parameter int                ADDR_W   = ADDR_W_D,
    parameter int                FC_W     = FC_W_D,
    parameter int                OFS_W    = OFS_W_D,
    parameter logic [ADDR_W-1:0] CFG_ADDR = CFG_ADDR_D,
    parameter logic [FC_W-1:0]   CPU_FC   = CPU_FC_D
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [FC_W-1:0]   bus_fc,
    input  logic              bus_stb,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_wdata,
    output logic              cfg_sel,
    output logic [ADDR_W-1:0] cfg_rdata,
    output logic              win_hit,
    output logic [OFS_W-1:0]  win_offset
);
    localparam int BASE_W = ADDR_W - OFS_W;

    acc_kind_e         kind;
    logic              cpu_space;
    logic [BASE_W-1:0] base_q;
    logic              valid_q;
    logic [ADDR_W-1:0] rd_word;
    logic              wdata_unused;

    assign wdata_unused = ^bus_wdata[OFS_W-1:1];

    win_cfg_decode #(
        .ADDR_W(ADDR_W), .FC_W(FC_W), .CFG_ADDR(CFG_ADDR), .CPU_FC(CPU_FC)
    ) u_dec (
        .addr(bus_addr), .fc(bus_fc), .stb(bus_stb), .wr(bus_wr),
        .kind(kind), .cpu_space(cpu_space)
    );

    win_base_reg #(.ADDR_W(ADDR_W), .OFS_W(OFS_W)) u_reg (
        .clk(clk), .rst(rst),
        .wr_en(kind == ACC_CFG_WR),
        .base_d(bus_wdata[ADDR_W-1:OFS_W]),
        .valid_d(bus_wdata[0]),
        .base_q(base_q), .valid_q(valid_q), .rd_word(rd_word)
    );

    win_match #(.ADDR_W(ADDR_W), .OFS_W(OFS_W)) u_match (
        .addr(bus_addr), .base(base_q), .enable(valid_q),
        .qualify(bus_stb && !cpu_space),
        .hit(win_hit), .offset(win_offset)
    );

    assign cfg_sel   = is_cfg(kind);
    assign cfg_rdata = (kind == ACC_CFG_RD) ? rd_word : '0;
endmodule

// File: rtl/win_decoder_chk.sv
module win_decoder_chk #(
    parameter int                ADDR_W   = 32,
    parameter int                FC_W     = 3,
    parameter int                OFS_W    = 13,
    parameter logic [ADDR_W-1:0] CFG_ADDR = 32'h0003_FF00,
    parameter logic [FC_W-1:0]   CPU_FC   = 3'b111,
    localparam int BASE_W = ADDR_W - OFS_W
) (
    input logic              clk,
    input logic              rst,
    input logic [ADDR_W-1:0] bus_addr,
    input logic [FC_W-1:0]   bus_fc,
    input logic              bus_stb,
    input logic              bus_wr,
    input logic [ADDR_W-1:0] bus_wdata,
    input logic              cfg_sel,
    input logic [ADDR_W-1:0] cfg_rdata,
    input logic              win_hit,
    input logic [OFS_W-1:0]  win_offset,
    input logic [BASE_W-1:0] base_q,
    input logic              valid_q
);
    // R1
    reset_clears_chk: assert property (@(posedge clk)
        rst |=> (!valid_q && base_q == '0));

    // R2
    cfg_sel_decode_chk: assert property (@(posedge clk) disable iff (rst)
        cfg_sel |-> (bus_stb && bus_fc == CPU_FC && bus_addr == CFG_ADDR));

    // R5
    hit_outside_cpu_chk: assert property (@(posedge clk) disable iff (rst)
        win_hit |-> (bus_fc != CPU_FC && valid_q));

    // R6
    cpu_other_addr_chk: assert property (@(posedge clk) disable iff (rst)
        (bus_fc == CPU_FC && bus_addr != CFG_ADDR) |-> (!cfg_sel && !win_hit));

    // R7
    offset_idle_chk: assert property (@(posedge clk) disable iff (rst)
        !win_hit |-> (win_offset == '0));

    // R8
    rdata_idle_chk: assert property (@(posedge clk) disable iff (rst)
        !(cfg_sel && !bus_wr) |-> (cfg_rdata == '0));

    // R9
    reg_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !(cfg_sel && bus_wr) |=> ($stable(base_q) && $stable(valid_q)));

    // R4
    reg_load_chk: assert property (@(posedge clk) disable iff (rst)
        (cfg_sel && bus_wr) |=>
            (valid_q == $past(bus_wdata[0]) && base_q == $past(bus_wdata[ADDR_W-1:OFS_W])));
endmodule

bind win_decoder win_decoder_chk #(
    .ADDR_W(ADDR_W), .FC_W(FC_W), .OFS_W(OFS_W), .CFG_ADDR(CFG_ADDR), .CPU_FC(CPU_FC)
) u_chk (
    .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_fc(bus_fc), .bus_stb(bus_stb),
    .bus_wr(bus_wr), .bus_wdata(bus_wdata), .cfg_sel(cfg_sel), .cfg_rdata(cfg_rdata),
    .win_hit(win_hit), .win_offset(win_offset), .base_q(base_q), .valid_q(valid_q)
);

// File: tb/win_decoder_tb.sv
`timescale 1ns/1ps
module win_decoder_tb;
    localparam logic [31:0] CFG_A = 32'h0003_FF00;
    localparam int          CLK_NS = 10;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [31:0] bus_addr = '0;
    logic [2:0]  bus_fc = '0;
    logic        bus_stb = 1'b0;
    logic        bus_wr = 1'b0;
    logic [31:0] bus_wdata = '0;
    logic        cfg_sel;
    logic [31:0] cfg_rdata;
    logic        win_hit;
    logic [12:0] win_offset;

    int checks = 0;
    int fails  = 0;

    logic [18:0] m_base  = '0;
    logic        m_valid = 1'b0;

    always #(CLK_NS/2) clk = ~clk;

    win_decoder u_dut (
        .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_fc(bus_fc),
        .bus_stb(bus_stb), .bus_wr(bus_wr), .bus_wdata(bus_wdata),
        .cfg_sel(cfg_sel), .cfg_rdata(cfg_rdata),
        .win_hit(win_hit), .win_offset(win_offset)
    );

    function automatic logic exp_sel(logic [31:0] a, logic [2:0] f, logic s);
        return s && f == 3'b111 && a == CFG_A;
    endfunction

    function automatic logic exp_hit(logic [31:0] a, logic [2:0] f, logic s);
        return s && m_valid && f != 3'b111 && a[31:13] == m_base;
    endfunction

    function automatic logic [31:0] exp_word();
        return {m_base, 12'b0, m_valid};
    endfunction

    task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=0x%08h expected=0x%08h", req, act, exp);
        end
    endtask

    // One bus cycle: drive away from the edge, check combinational outputs, then clock.
    task automatic cyc(logic [31:0] a, logic [2:0] f, logic s, logic w, logic [31:0] d);
        logic sel_e, hit_e;
        @(negedge clk);
        bus_addr = a; bus_fc = f; bus_stb = s; bus_wr = w; bus_wdata = d;
        #1;
        sel_e = exp_sel(a, f, s);
        hit_e = exp_hit(a, f, s);
        chk("R2", {31'b0, cfg_sel}, {31'b0, sel_e});
        chk("R5", {31'b0, win_hit}, {31'b0, hit_e});
        if (hit_e) chk("R5", {19'b0, win_offset}, {19'b0, a[12:0]});
        else       chk("R7", {19'b0, win_offset}, 32'h0);
        chk("R8", cfg_rdata, (sel_e && !w) ? exp_word() : 32'h0);
        @(posedge clk);
        #1;
        if (sel_e && w) begin
            m_base  = d[31:13];
            m_valid = d[0];
        end
    endtask

    task automatic read_cfg(string req, logic [31:0] exp);
        cyc(CFG_A, 3'b111, 1'b1, 1'b0, 32'h0);
        @(negedge clk);
        bus_addr = CFG_A; bus_fc = 3'b111; bus_stb = 1'b1; bus_wr = 1'b0;
        #1;
        chk(req, cfg_rdata, exp);
    endtask

    initial begin
        #(CLK_NS * 150000);
        fails++;
        $display("FAIL watchdog actual=running expected=finished");
        $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        logic [31:0] a;
        logic [31:0] d;
        int unsigned seed;
        seed = $urandom(32'd2024);
        repeat (3) @(posedge clk);
        #1;
        rst = 1'b0;

        // R1: reset state
        read_cfg("R1", 32'h0);
        cyc(32'h0, 3'b101, 1'b1, 1'b0, 32'h0);
        chk("R1", {31'b0, win_hit}, 32'h0);

        // R4: low bits dropped, valid in bit 0
        cyc(CFG_A, 3'b111, 1'b1, 1'b1, 32'h0040_3FFF);
        read_cfg("R4", 32'h0040_2001);

        // R5: window edges
        cyc(32'h0040_3FFF, 3'b101, 1'b1, 1'b0, 32'h0);
        chk("R5", {18'b0, win_hit, win_offset}, {18'b0, 1'b1, 13'h1FFF});
        cyc(32'h0040_2000, 3'b001, 1'b1, 1'b0, 32'h0);
        chk("R5", {18'b0, win_hit, win_offset}, {18'b0, 1'b1, 13'h0000});
        cyc(32'h0040_4000, 3'b101, 1'b1, 1'b0, 32'h0);
        chk("R5", {31'b0, win_hit}, 32'h0);
        cyc(32'h0040_1FFF, 3'b101, 1'b1, 1'b0, 32'h0);
        chk("R5", {31'b0, win_hit}, 32'h0);

        // R6: CPU space elsewhere, including inside the window
        cyc(32'h0040_2010, 3'b111, 1'b1, 1'b0, 32'h0);
        chk("R6", {30'b0, cfg_sel, win_hit}, 32'h0);
        cyc(32'h0003_FF04, 3'b111, 1'b1, 1'b1, 32'h0);
        chk("R6", {30'b0, cfg_sel, win_hit}, 32'h0);

        // R3: register address with every non-CPU function code
        for (int f = 0; f < 7; f++) begin
            cyc(CFG_A, 3'(f), 1'b1, 1'b1, 32'hFFFF_E000);
            chk("R3", {31'b0, cfg_sel}, 32'h0);
        end
        read_cfg("R3", 32'h0040_2001);

        // R9: write without strobe changes nothing
        cyc(CFG_A, 3'b111, 1'b0, 1'b1, 32'h1234_6001);
        read_cfg("R9", 32'h0040_2001);
        cyc(CFG_A, 3'b111, 1'b1, 1'b1, 32'h1234_6001);
        read_cfg("R9", 32'h1234_6001);

        // R7: clearing the valid flag removes all hits
        cyc(CFG_A, 3'b111, 1'b1, 1'b1, 32'h1234_6000);
        cyc(32'h1234_6ABC, 3'b010, 1'b1, 1'b0, 32'h0);
        chk("R7", {18'b0, win_hit, win_offset}, 32'h0);

        // Random traffic
        for (int i = 0; i < 2000; i++) begin
            case ($urandom % 4)
                0: a = CFG_A;
                1: a = {m_base, 13'($urandom)};
                2: a = {m_base + 19'($urandom % 3) - 19'd1, 13'($urandom)};
                default: a = $urandom;
            endcase
            d = $urandom;
            cyc(a, 3'($urandom), ($urandom % 8) != 0, 1'($urandom), d);
        end

        $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule